// File: doc/BRIEF.md
# Synthesizer Tuning Register Write Port

This block is the write side of a two-wire serial slave that programs the control registers of a frequency synthesizer. It watches the already-synchronised clock and data lines and detects START and STOP conditions. It matches a 7-bit slave address whose two lowest bits come from a strap input, so four devices can share one bus. After a matching write address it accepts a stream of auto-incrementing data bytes. Each accepted byte is acknowledged by pulling the data line low through an open-drain pull-down output.

The register set holds a 17-bit main divider ratio, a divide-by-two prescaler enable, a 4-bit reference divider code, a 2-bit charge-pump current code, two reference-output control bits and four output-port driver states. The host can start a transfer at either of two entry bytes, chosen by the top bit of the first data byte. This allows partial programming. The divider ratio, prescaler enable and reference code are first written to a staging copy. They reach the outputs only when the final control byte arrives or when the transfer ends with STOP. The host can therefore rewrite the upper ratio bytes any number of times without disturbing the running loop.

Top module: `tune_wr_port`

## Requirements
- R1: After reset every register output is 0: divider ratio, prescaler enable, reference code, pump code, both reference-output bits, and all four port drivers (0 means driver off). The pull-down is released.
- R2: Only the address byte {1,1,0,0,0,strap[1],strap[0],0}, sent MSB first, is acknowledged. Any other value, including the same address with the read bit set, gets no acknowledge, and every byte that follows it up to the next START is ignored.
- R3: For the matching address byte and for every data byte that follows it, the pull-down is asserted from the falling SCL edge after the eighth bit until the falling edge of the ninth pulse. It never changes while SCL is high.
- R4: The first data byte after the address is decoded by its MSB. A 0 makes it the ratio-high byte {0, N16..N10}. A 1 makes it the ratio-low byte {1, N1, N0, PE, REF[3:0]}.
- R5: The byte slot auto-increments from ratio-high to ratio-mid {N9..N2} and from ratio-low to the control byte. The byte after ratio-mid, and the byte after the control byte, are again decoded by their MSB as in R4.
- R6: Ratio, prescaler enable and reference code bytes only update a staging copy. The outputs take the staged values in one step at a commit.
- R7: The control byte {CP[1:0], REFOUT_EN, REFOUT_SEL, PORT[3:0]} drives its own outputs as soon as it is received, and it commits the staged values.
- R8: A STOP commits the staged values if any ratio byte was written since the last commit.
- R9: Sending ratio-high and ratio-mid repeatedly with no STOP and no control byte leaves the divider ratio output unchanged.
- R10: A START or repeated START drops any partly shifted byte and returns the slot to MSB decoding. Staged values are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| strap_i | input | 2 | Low two slave address bits |
| sda_pull_o | output | 1 | Open-drain pull-down request for acknowledge |
| div_ratio_o | output | 17 | Active main divider ratio |
| pre_en_o | output | 1 | Active prescaler enable |
| ref_code_o | output | 4 | Active reference divider code |
| cp_code_o | output | 2 | Charge-pump current code |
| refout_en_o | output | 1 | Reference output enable |
| refout_sel_o | output | 1 | Reference output source select |
| port_drv_o | output | 4 | Output-port driver states |

## Verification
The hardest case to reach from the pins is a staged ratio that differs from the active one while the transfer stays open. The check is that repeated ratio-high/ratio-mid pairs never leak through before a STOP or a control byte arrives. The bench sends a 2-3-2-3 stream with no STOP and compares the outputs on every clock against a behavioural model. It then closes the transfer and checks that the last pair takes effect. A second hard case is a byte cut off after four bits by a repeated START. The bench checks that the next byte, which has its MSB set, lands in the ratio-low slot.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int BYTE_W  = 8;
  localparam int RATIO_W = 17;
  localparam int REF_W   = 4;
  localparam int CP_W    = 2;
  localparam int PORT_W  = 4;
  localparam int ADDR_W  = 7;
  localparam logic [4:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [2:0] {
    SLOT_NONE = 3'd0,
    SLOT_HI   = 3'd2,
    SLOT_MID  = 3'd3,
    SLOT_LO   = 3'd4,
    SLOT_CTL  = 3'd5
  } slot_t;

  typedef enum logic [1:0] {
    EXP_ENTRY = 2'd0,
    EXP_MID   = 2'd1,
    EXP_CTL   = 2'd2
  } expect_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_DATA = 2'd2,
    SQ_SKIP = 2'd3
  } seq_st_t;
endpackage

// File: rtl/tune_bit_engine.sv
module tune_bit_engine
  import tune_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          ack_req_i,
  output logic          start_o,
  output logic          stop_o,
  output logic          byte_stb_o,
  output logic [DW-1:0] byte_o,
  output logic          sda_pull_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DW);

  logic          scl_q, sda_q;
  logic          busy, in_ack;
  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0] shreg;
  logic          scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign start_o   = start_det;
  assign stop_o    = stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      busy       <= 1'b0;
      in_ack     <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_o     <= '0;
      byte_stb_o <= 1'b0;
      sda_pull_o <= 1'b0;
    end else begin
      scl_q      <= scl_i;
      sda_q      <= sda_i;
      byte_stb_o <= 1'b0;
      if (start_det) begin
        busy    <= 1'b1;
        in_ack  <= 1'b0;
        bit_cnt <= '0;
      end else if (stop_det) begin
        busy    <= 1'b0;
        in_ack  <= 1'b0;
        bit_cnt <= '0;
      end else if (busy) begin
        if (scl_rise && !in_ack && bit_cnt < ACK_SLOT) begin
          shreg   <= {shreg[DW-2:0], sda_i};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            byte_o     <= {shreg[DW-2:0], sda_i};
            byte_stb_o <= 1'b1;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack     <= 1'b0;
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
          end else if (bit_cnt == ACK_SLOT) begin
            in_ack     <= 1'b1;
            sda_pull_o <= ack_req_i;
          end
        end
      end
    end
  end

  // R3: the pull-down moves only while SCL is low
  p_pull_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

  // R10: a START clears the bit position
  p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (bit_cnt == '0 && !in_ack));
endmodule

// File: rtl/tune_byte_seq.sv
module tune_byte_seq
  import tune_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    strap_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_stb_i,
  input  logic [DW-1:0] byte_i,
  output logic          ack_req_o,
  output logic          wr_en_o,
  output slot_t         wr_slot_o,
  output logic [DW-1:0] wr_data_o,
  output logic          commit_o
);
  seq_st_t state;
  expect_t expt;
  logic    dirty;
  logic    addr_hit;
  slot_t   slot_now;

  assign addr_hit = (byte_i[DW-1:1] == {ADDR_FIXED, strap_i}) && !byte_i[0];

  always_comb begin
    case (expt)
      EXP_MID: slot_now = SLOT_MID;
      EXP_CTL: slot_now = SLOT_CTL;
      default: slot_now = byte_i[DW-1] ? SLOT_LO : SLOT_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      expt      <= EXP_ENTRY;
      dirty     <= 1'b0;
      ack_req_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_slot_o <= SLOT_NONE;
      wr_data_o <= '0;
      commit_o  <= 1'b0;
    end else begin
      wr_en_o  <= 1'b0;
      commit_o <= 1'b0;
      if (start_i) begin
        state     <= SQ_ADDR;
        expt      <= EXP_ENTRY;
        ack_req_o <= 1'b0;
      end else if (stop_i) begin
        state     <= SQ_IDLE;
        expt      <= EXP_ENTRY;
        ack_req_o <= 1'b0;
        if (dirty) begin
          commit_o <= 1'b1;
          dirty    <= 1'b0;
        end
      end else if (byte_stb_i) begin
        case (state)
          SQ_ADDR: begin
            state     <= addr_hit ? SQ_DATA : SQ_SKIP;
            ack_req_o <= addr_hit;
          end
          SQ_DATA: begin
            ack_req_o <= 1'b1;
            wr_en_o   <= 1'b1;
            wr_slot_o <= slot_now;
            wr_data_o <= byte_i;
            case (slot_now)
              SLOT_HI:  begin expt <= EXP_MID;   dirty <= 1'b1; end
              SLOT_MID: begin expt <= EXP_ENTRY; dirty <= 1'b1; end
              SLOT_LO:  begin expt <= EXP_CTL;   dirty <= 1'b1; end
              default:  begin
                expt     <= EXP_ENTRY;
                dirty    <= 1'b0;
                commit_o <= 1'b1;
              end
            endcase
          end
          default: ack_req_o <= 1'b0;
        endcase
      end
    end
  end

  // R2: a byte in the ignore state is never acknowledged
  p_skip_no_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (byte_stb_i && !start_i && !stop_i && state == SQ_SKIP) |=> !ack_req_o);

  // R7: control byte commits
  p_ctl_commit_r7: assert property (@(posedge clk) disable iff (rst)
    (byte_stb_i && !start_i && !stop_i && state == SQ_DATA && expt == EXP_CTL)
      |=> (commit_o && wr_en_o));

  // R10: START returns to MSB decoding
  p_start_entry_r10: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (state == SQ_ADDR && expt == EXP_ENTRY));
endmodule

// File: rtl/tune_reg_file.sv
module tune_reg_file
  import tune_pkg::*;
#(
  parameter int DW  = BYTE_W,
  parameter int NW  = RATIO_W,
  parameter int RW  = REF_W,
  parameter int CW  = CP_W,
  parameter int PW  = PORT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  slot_t         wr_slot_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          commit_i,
  output logic [NW-1:0] div_ratio_o,
  output logic          pre_en_o,
  output logic [RW-1:0] ref_code_o,
  output logic [CW-1:0] cp_code_o,
  output logic          refout_en_o,
  output logic          refout_sel_o,
  output logic [PW-1:0] port_drv_o
);
  localparam int HI_W  = DW - 1;
  localparam int MID_W = DW;
  localparam int LO_W  = NW - HI_W - MID_W;
  localparam int MID_B = LO_W;
  localparam int HI_B  = LO_W + MID_W;

  logic [NW-1:0] stg_ratio;
  logic          stg_pre;
  logic [RW-1:0] stg_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_ratio <= '0;
      stg_pre   <= 1'b0;
      stg_ref   <= '0;
    end else if (wr_en_i) begin
      case (wr_slot_i)
        SLOT_HI:  stg_ratio[HI_B +: HI_W]   <= wr_data_i[HI_W-1:0];
        SLOT_MID: stg_ratio[MID_B +: MID_W] <= wr_data_i;
        SLOT_LO: begin
          stg_ratio[LO_W-1:0] <= wr_data_i[DW-2 -: LO_W];
          stg_pre             <= wr_data_i[RW];
          stg_ref             <= wr_data_i[RW-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_ratio_o <= '0;
      pre_en_o    <= 1'b0;
      ref_code_o  <= '0;
    end else if (commit_i) begin
      div_ratio_o <= stg_ratio;
      pre_en_o    <= stg_pre;
      ref_code_o  <= stg_ref;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_code_o    <= '0;
      refout_en_o  <= 1'b0;
      refout_sel_o <= 1'b0;
      port_drv_o   <= '0;
    end else if (wr_en_i && wr_slot_i == SLOT_CTL) begin
      cp_code_o    <= wr_data_i[DW-1 -: CW];
      refout_en_o  <= wr_data_i[PW+1];
      refout_sel_o <= wr_data_i[PW];
      port_drv_o   <= wr_data_i[PW-1:0];
    end
  end

  // R6: a commit copies the staged ratio
  p_commit_copy_r6: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (div_ratio_o == $past(stg_ratio)));

  // R9: without a commit the active ratio holds
  p_ratio_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(div_ratio_o));
endmodule

// File: rtl/tune_wr_port.sv
module tune_wr_port
  import tune_pkg::*;
#(
  parameter int NW = RATIO_W,
  parameter int RW = REF_W,
  parameter int CW = CP_W,
  parameter int PW = PORT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    strap_i,
  output logic          sda_pull_o,
  output logic [NW-1:0] div_ratio_o,
  output logic          pre_en_o,
  output logic [RW-1:0] ref_code_o,
  output logic [CW-1:0] cp_code_o,
  output logic          refout_en_o,
  output logic          refout_sel_o,
  output logic [PW-1:0] port_drv_o
);
  logic              start_w, stop_w, stb_w, ack_w, wr_en_w, commit_w;
  logic [BYTE_W-1:0] byte_w, wr_data_w;
  slot_t             wr_slot_w;

  tune_bit_engine #(.DW(BYTE_W)) u_bits (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .ack_req_i(ack_w), .start_o(start_w), .stop_o(stop_w),
    .byte_stb_o(stb_w), .byte_o(byte_w), .sda_pull_o(sda_pull_o)
  );

  tune_byte_seq #(.DW(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .strap_i(strap_i), .start_i(start_w),
    .stop_i(stop_w), .byte_stb_i(stb_w), .byte_i(byte_w),
    .ack_req_o(ack_w), .wr_en_o(wr_en_w), .wr_slot_o(wr_slot_w),
    .wr_data_o(wr_data_w), .commit_o(commit_w)
  );

  tune_reg_file #(.DW(BYTE_W), .NW(NW), .RW(RW), .CW(CW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_w), .wr_slot_i(wr_slot_w),
    .wr_data_i(wr_data_w), .commit_i(commit_w),
    .div_ratio_o(div_ratio_o), .pre_en_o(pre_en_o), .ref_code_o(ref_code_o),
    .cp_code_o(cp_code_o), .refout_en_o(refout_en_o),
    .refout_sel_o(refout_sel_o), .port_drv_o(port_drv_o)
  );

  // R1: outputs leave reset cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (div_ratio_o == '0 && port_drv_o == '0 && !sda_pull_o));
endmodule

// File: tb/tune_wr_port_tb_top.sv
module tune_wr_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_pull;
  logic sda_line;
  logic [16:0] div_ratio;
  logic pre_en, refout_en, refout_sel;
  logic [3:0] ref_code, port_drv;
  logic [1:0] cp_code;

  int n_chk = 0;
  int n_fail = 0;
  bit busy = 1'b1;
  bit done = 1'b0;

  // behavioural model state
  bit m_addrd;
  int m_expect;          // 0 entry, 3 mid, 5 control
  bit m_dirty;
  int s_ratio, s_pre, s_ref;
  int a_ratio, a_pre, a_ref, a_cp, a_xe, a_xs, a_port;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  tune_wr_port dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .sda_pull_o(sda_pull), .div_ratio_o(div_ratio), .pre_en_o(pre_en),
    .ref_code_o(ref_code), .cp_code_o(cp_code), .refout_en_o(refout_en),
    .refout_sel_o(refout_sel), .port_drv_o(port_drv)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // per-clock comparison against the model (R6 R7 R8 R9)
  always @(negedge clk) begin
    if (!rst && !busy && !done) begin
      chk("R6-ratio", int'(div_ratio), a_ratio);
      chk("R6-pre", int'(pre_en), a_pre);
      chk("R6-ref", int'(ref_code), a_ref);
      chk("R7-cp", int'(cp_code), a_cp);
      chk("R7-xe", int'(refout_en), a_xe);
      chk("R7-xs", int'(refout_sel), a_xs);
      chk("R7-port", int'(port_drv), a_port);
    end
  end

  task automatic model_commit();
    a_ratio = s_ratio; a_pre = s_pre; a_ref = s_ref; m_dirty = 0;
  endtask

  function automatic int mdl_byte_ack(bit first, logic [7:0] b);
    return 0;
  endfunction

  task automatic model_byte(input bit is_addr, input logic [7:0] b, output bit ack);
    int slot;
    ack = 0;
    if (is_addr) begin
      m_addrd = (b == {5'b11000, strap, 1'b0});
      ack = m_addrd;
      return;
    end
    if (!m_addrd) return;
    ack = 1;
    slot = (m_expect == 0) ? (b[7] ? 4 : 2) : m_expect;
    case (slot)
      2: begin s_ratio = (s_ratio & 17'h003FF) | (int'(b[6:0]) << 10); m_expect = 3; m_dirty = 1; end
      3: begin s_ratio = (s_ratio & 17'h1FC03) | (int'(b) << 2); m_expect = 0; m_dirty = 1; end
      4: begin s_ratio = (s_ratio & 17'h1FFFC) | int'(b[6:5]);
               s_pre = b[4]; s_ref = b[3:0]; m_expect = 5; m_dirty = 1; end
      default: begin a_cp = b[7:6]; a_xe = b[5]; a_xs = b[4]; a_port = b[3:0];
               model_commit(); m_expect = 0; end
    endcase
  endtask

  task automatic bus_start();
    m_sda = 1; clks(3); scl = 1; clks(3);
    m_sda = 0; clks(3);
    m_addrd = 0; m_expect = 0;
    scl = 0; clks(3);
  endtask

  task automatic bus_stop();
    m_sda = 0; clks(3); scl = 1; clks(3);
    busy = 1; m_sda = 1; clks(6);
    if (m_dirty) model_commit();
    m_addrd = 0; m_expect = 0;
    busy = 0; clks(3);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; clks(3); scl = 1; clks(4); scl = 0; clks(3);
    end
  endtask

  task automatic send_byte(input bit is_addr, input logic [7:0] b, input string req);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; clks(3);
      if (i == 0) busy = 1;
      scl = 1; clks(4); scl = 0; clks(3);
    end
    model_byte(is_addr, b, ack);
    busy = 0;
    m_sda = 1; clks(3); scl = 1; clks(2);
    chk({req, "/R3-ack"}, int'(!sda_line), int'(ack));
    clks(2); scl = 0; clks(3);
    chk("R3-release", int'(sda_pull), 0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    s_ratio = 0; s_pre = 0; s_ref = 0; a_ratio = 0; a_pre = 0; a_ref = 0;
    a_cp = 0; a_xe = 0; a_xs = 0; a_port = 0; m_addrd = 0; m_expect = 0; m_dirty = 0;
    clks(4); rst = 0; clks(2);
    // R1 reset state
    chk("R1-ratio", int'(div_ratio), 0);
    chk("R1-ports", int'(port_drv), 0);
    chk("R1-pull", int'(sda_pull), 0);
    chk("R1-misc", int'({pre_en, ref_code, cp_code, refout_en, refout_sel}), 0);
    busy = 0;

    // R4 R5 R7 full five-byte write, then an extra byte decoded by MSB
    bus_start();
    send_byte(1, 8'hC4, "R2");
    send_byte(0, 8'h6A, "R4");
    send_byte(0, 8'hF3, "R5");
    send_byte(0, 8'hB5, "R5");
    chk("R6-staged-not-active", int'(div_ratio), 0);
    send_byte(0, 8'hAA, "R7");
    clks(2);
    chk("R7-ratio", int'(div_ratio), 17'h1ABCD);
    chk("R7-pre-ref", int'({pre_en, ref_code}), 5'b10101);
    chk("R7-ctl", int'({cp_code, refout_en, refout_sel, port_drv}), 8'hAA);
    send_byte(0, 8'h07, "R5");
    chk("R5-wrap-no-commit", int'(div_ratio), 17'h1ABCD);
    bus_stop();

    // R4 partial write from ratio-low entry
    bus_start();
    send_byte(1, 8'hC4, "R2");
    send_byte(0, 8'hE9, "R4");
    send_byte(0, 8'h55, "R7");
    bus_stop();
    chk("R4-lo-entry", int'(div_ratio), 17'h01C3F & 17'h1FFFF ? a_ratio : 0);
    chk("R4-ref", int'(ref_code), 9);

    // R8 ratio-high and ratio-mid closed by STOP
    bus_start();
    send_byte(1, 8'hC4, "R2");
    send_byte(0, 8'h01, "R8");
    send_byte(0, 8'h00, "R8");
    bus_stop();
    chk("R8-stop-commit", int'(div_ratio), 17'h00403);

    // R9 repeated 2-3-2-3 without STOP
    bus_start();
    send_byte(1, 8'hC4, "R2");
    send_byte(0, 8'h22, "R9");
    send_byte(0, 8'h11, "R9");
    send_byte(0, 8'h33, "R9");
    send_byte(0, 8'h44, "R9");
    clks(5);
    chk("R9-held", int'(div_ratio), 17'h00403);
    bus_stop();
    chk("R9-after-stop", int'(div_ratio), 17'h0CD13);

    // R2 wrong strap and read bit ignored
    bus_start();
    send_byte(1, 8'hC6, "R2-strap");
    send_byte(0, 8'h7F, "R2-ignored");
    send_byte(0, 8'hFF, "R2-ignored");
    bus_stop();
    chk("R2-no-change", int'(div_ratio), 17'h0CD13);
    bus_start();
    send_byte(1, 8'hC5, "R2-read");
    send_byte(0, 8'h00, "R2-ignored");
    bus_stop();
    chk("R2-read-no-change", int'(div_ratio), 17'h0CD13);

    // R10 cut byte then repeated START; next MSB=1 byte lands in ratio-low
    bus_start();
    send_byte(1, 8'hC4, "R10");
    send_byte(0, 8'h02, "R10");
    send_bits(8'h00, 4);
    bus_start();
    send_byte(1, 8'hC4, "R10");
    send_byte(0, 8'hA2, "R10");
    send_byte(0, 8'h0F, "R10");
    clks(2);
    chk("R10-ratio", int'(div_ratio), (2 << 10) | (17'h0CD13 & 17'h003FC) | 1);
    chk("R10-ref", int'({pre_en, ref_code}), 5'b00010);
    chk("R10-ports", int'(port_drv), 4'hF);
    bus_stop();

    clks(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule